// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block sits next to the load/store pipe and decides whether a cache-block zero, clean/flush or invalidate operation may proceed at the current privilege level. It looks at the operation class, the privilege level, whether the hart runs virtualized, and the enable fields of three environment-configuration levels (machine, hypervisor, supervisor). A fixed-priority cascade over those enables yields either no exception, an illegal-instruction exception or a virtual-instruction exception.

Alongside the verdict the block rounds the effective address down to the start of its cache block. Zero operations and management operations each have their own block size. A request is sampled on a rising edge and its registered response is valid for exactly one cycle after it. Translation, protection probing and the memory side effect itself belong to other units.

Top module: `cbo_perm_chk`

## Requirements
- R1: `op_i` selects the enable field: 0 selects zero (cfg bit 0), 1 selects clean/flush (cfg bit 1), 2 and 3 select invalidate (cfg bits [3:2]). A field counts as enabled when any of its bits is set.
- R2: When the privilege (U=0, S=1, M=3) is below M and the machine-level field is clear, the response is an illegal-instruction exception (cause 2), whatever the other levels hold.
- R3: Otherwise, when `virt_i` is set and either the privilege is U or S with the hypervisor field clear, or the privilege is U with the supervisor field clear, the response is a virtual-instruction exception (cause 22).
- R4: Otherwise, when the privilege is U and the supervisor field is clear, the response is an illegal-instruction exception (cause 2).
- R5: At privilege M no exception is raised for any configuration or virtualization state.
- R6: When no exception is raised, `exc_o` is 0 and `cause_o` is 0.
- R7: `addr_o` is `addr_i` with its low bits cleared to a multiple of `ZERO_BLK` for op 0 and of `MGMT_BLK` for all other ops, whether or not an exception is raised.
- R8: `valid_o` is high in the cycle after a cycle with `req_i` high, and low after a cycle with `req_i` low.
- R9: While `rst_ni` is low, `valid_o`, `exc_o`, `cause_o` and `addr_o` are all 0.
- R10: Enable fields not selected by `op_i` have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation class |
| priv_i | input | 2 | Current privilege: U=0, S=1, M=3 |
| virt_i | input | 1 | Virtualization active |
| m_cfg_i | input | 4 | Machine-level enable fields |
| h_cfg_i | input | 4 | Hypervisor-level enable fields |
| s_cfg_i | input | 4 | Supervisor-level enable fields |
| addr_i | input | AW | Effective address |
| valid_o | output | 1 | Response valid |
| exc_o | output | 1 | Exception raised |
| cause_o | output | 5 | Exception cause, 0 when none |
| addr_o | output | AW | Block-aligned address |

## Verification
The assertions check the following on every cycle: the one-cycle response timing, the top priority of the machine-level check, the absence of exceptions at M, the zero cause on a clean response, the legal cause values and the zero-block alignment. Whether the hypervisor and supervisor checks choose the right cause in the right order, the any-bit handling of the invalidate field, and the lack of effect of unselected fields can only be shown by the bench. It walks every privilege, virtualization and per-level enable combination for all op codes and compares each response against an independent priority model.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;
  localparam int unsigned CFG_W   = 4;
  localparam int unsigned CAUSE_W = 5;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned LVL_M   = 0;
  localparam int unsigned LVL_H   = 1;
  localparam int unsigned LVL_S   = 2;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE    = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT    = 5'd22;
endpackage

// File: rtl/cbo_en_sel.sv
module cbo_en_sel
  import cbo_perm_pkg::*;
(
  input  logic [1:0]       op_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             en_o
);
  // R1: invalidate field is two bits wide, any bit enables
  always_comb begin
    unique case (op_i)
      2'd0:    en_o = cfg_i[0];
      2'd1:    en_o = cfg_i[1];
      default: en_o = |cfg_i[3:2];
    endcase
  end
endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
  import cbo_perm_pkg::*;
(
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               m_en_i,
  input  logic               h_en_i,
  input  logic               s_en_i,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic below_m, at_most_s, below_s;

  assign below_m   = (priv_i != PRIV_M);
  assign at_most_s = (priv_i <= PRIV_S);
  assign below_s   = (priv_i == PRIV_U);

  // fixed order: machine, then virtual, then supervisor
  always_comb begin
    exc_o   = 1'b0;
    cause_o = CAUSE_NONE;
    if (below_m && !m_en_i) begin
      exc_o   = 1'b1;
      cause_o = CAUSE_ILLEGAL;
    end else if (virt_i && ((at_most_s && !h_en_i) || (below_s && !s_en_i))) begin
      exc_o   = 1'b1;
      cause_o = CAUSE_VIRT;
    end else if (below_s && !s_en_i) begin
      exc_o   = 1'b1;
      cause_o = CAUSE_ILLEGAL;
    end
  end
endmodule

// File: rtl/cbo_align.sv
module cbo_align #(
  parameter int unsigned AW  = 64,
  parameter int unsigned BLK = 64
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'(BLK - 1);

  assign addr_o = addr_i & ~LOW_MASK;
endmodule

// File: rtl/cbo_perm_chk.sv
module cbo_perm_chk
  import cbo_perm_pkg::*;
#(
  parameter int unsigned AW       = 64,
  parameter int unsigned ZERO_BLK = 64,
  parameter int unsigned MGMT_BLK = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [1:0]         op_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [CFG_W-1:0]   m_cfg_i,
  input  logic [CFG_W-1:0]   h_cfg_i,
  input  logic [CFG_W-1:0]   s_cfg_i,
  input  logic [AW-1:0]      addr_i,
  output logic               valid_o,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AW-1:0]      addr_o
);
  localparam logic [AW-1:0] ZERO_LOW = AW'(ZERO_BLK - 1);

  logic [NUM_LVL-1:0][CFG_W-1:0] lvl_cfg;
  logic [NUM_LVL-1:0]            lvl_en;
  logic                          exc_d;
  logic [CAUSE_W-1:0]            cause_d;
  logic [AW-1:0]                 zero_addr, mgmt_addr, addr_d;

  assign lvl_cfg[LVL_M] = m_cfg_i;
  assign lvl_cfg[LVL_H] = h_cfg_i;
  assign lvl_cfg[LVL_S] = s_cfg_i;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    cbo_en_sel u_sel (
      .op_i  (op_i),
      .cfg_i (lvl_cfg[l]),
      .en_o  (lvl_en[l])
    );
  end

  cbo_gate u_gate (
    .priv_i  (priv_i),
    .virt_i  (virt_i),
    .m_en_i  (lvl_en[LVL_M]),
    .h_en_i  (lvl_en[LVL_H]),
    .s_en_i  (lvl_en[LVL_S]),
    .exc_o   (exc_d),
    .cause_o (cause_d)
  );

  cbo_align #(.AW(AW), .BLK(ZERO_BLK)) u_align_zero (
    .addr_i (addr_i),
    .addr_o (zero_addr)
  );

  cbo_align #(.AW(AW), .BLK(MGMT_BLK)) u_align_mgmt (
    .addr_i (addr_i),
    .addr_o (mgmt_addr)
  );

  assign addr_d = (op_i == 2'd0) ? zero_addr : mgmt_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      exc_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
      addr_o  <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        exc_o   <= exc_d;
        cause_o <= cause_d;
        addr_o  <= addr_d;
      end
    end
  end

  // R8
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  // R8
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  // R2
  m_level_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && priv_i != PRIV_M && !lvl_en[LVL_M]) |=> (exc_o && cause_o == CAUSE_ILLEGAL));
  // R5
  m_mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && priv_i == PRIV_M) |=> !exc_o);
  // R6
  clean_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !exc_o) |-> cause_o == CAUSE_NONE);
  // R3
  cause_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && exc_o) |-> (cause_o == CAUSE_ILLEGAL || cause_o == CAUSE_VIRT));
  // R7
  zero_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i == 2'd0) |=> (addr_o & ZERO_LOW) == '0);
endmodule

// File: tb/cbo_perm_chk_tb_top.sv
module cbo_perm_chk_tb_top;
  localparam int unsigned AW   = 64;
  localparam int unsigned ZBLK = 64;
  localparam int unsigned MBLK = 128;

  typedef struct {
    logic          exc;
    logic [4:0]    cause;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    op = '0;
  logic [1:0]    priv = '0;
  logic          virt = 1'b0;
  logic [3:0]    m_cfg = '0, h_cfg = '0, s_cfg = '0;
  logic [AW-1:0] addr = '0;
  logic          valid, exc;
  logic [4:0]    cause;
  logic [AW-1:0] addr_q;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  cbo_perm_chk #(.AW(AW), .ZERO_BLK(ZBLK), .MGMT_BLK(MBLK)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .op_i    (op),
    .priv_i  (priv),
    .virt_i  (virt),
    .m_cfg_i (m_cfg),
    .h_cfg_i (h_cfg),
    .s_cfg_i (s_cfg),
    .addr_i  (addr),
    .valid_o (valid),
    .exc_o   (exc),
    .cause_o (cause),
    .addr_o  (addr_q)
  );

  // selected field set or clear; every other field takes the opposite value (R10)
  function automatic logic [3:0] mk_cfg(int o, bit en, bit alt);
    case (o)
      0:       return en ? 4'b0001 : 4'b1110;
      1:       return en ? 4'b0010 : 4'b1101;
      default: return en ? (alt ? 4'b1000 : 4'b0100) : 4'b0011;
    endcase
  endfunction

  task automatic send(int o, int p, bit v, bit me, bit he, bit se, bit alt, logic [AW-1:0] a);
    exp_t e;
    @(negedge clk);
    req = 1'b1; op = 2'(o); priv = 2'(p); virt = v; addr = a;
    m_cfg = mk_cfg(o, me, alt); h_cfg = mk_cfg(o, he, alt); s_cfg = mk_cfg(o, se, alt);
    e.exc = 1'b0; e.cause = 5'd0; e.tag = "R6 R1 R10";
    case (p)
      0: begin
        if (!me)                   begin e.exc = 1; e.cause = 5'd2;  e.tag = "R2 R1 R10"; end
        else if (v && (!he || !se)) begin e.exc = 1; e.cause = 5'd22; e.tag = "R3 R1 R10"; end
        else if (!se)              begin e.exc = 1; e.cause = 5'd2;  e.tag = "R4 R1 R10"; end
      end
      1: begin
        if (!me)           begin e.exc = 1; e.cause = 5'd2;  e.tag = "R2 R1 R10"; end
        else if (v && !he) begin e.exc = 1; e.cause = 5'd22; e.tag = "R3 R1 R10"; end
      end
      default: e.tag = "R5 R1 R10";
    endcase
    e.addr = (o == 0) ? (a & ~AW'(ZBLK - 1)) : (a & ~AW'(MBLK - 1));
    sb_q.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req = 1'b0;
    end
  endtask

  // monitor: responses become visible just after the edge following the request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          checks++;
          if (!valid) begin
            fails++;
            $display("FAIL R8: valid_o=%0b expected 1", valid);
          end
          checks++;
          if (exc !== e.exc || cause !== e.cause) begin
            fails++;
            $display("FAIL %s: exc=%0b cause=%0d expected exc=%0b cause=%0d (op=%0d priv=%0d virt=%0b)",
                     e.tag, exc, cause, e.exc, e.cause, op, priv, virt);
          end
          checks++;
          if (addr_q !== e.addr) begin
            fails++;
            $display("FAIL R7: addr=%h expected %h", addr_q, e.addr);
          end
        end else begin
          checks++;
          if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R8: valid_o=%0b expected 0 when idle", valid);
          end
        end
      end
    end
  end

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: drive a request during reset, outputs must stay zero
    req = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (valid !== 1'b0 || exc !== 1'b0 || cause !== 5'd0 || addr_q !== '0) begin
      fails++;
      $display("FAIL R9: valid=%0b exc=%0b cause=%0d addr=%h expected all zero",
               valid, exc, cause, addr_q);
    end
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    idle(3);

    // exhaustive sweep: op x privilege x virt x three enables
    for (int o = 0; o < 4; o++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int v = 0; v < 2; v++) begin
          for (int e = 0; e < 8; e++) begin
            send(o, (pi == 2) ? 3 : pi, v[0], e[0], e[1], e[2], e[0] ^ e[1] ^ v[0],
                 {$urandom(), $urandom()});
          end
          idle(1);
        end
      end
    end

    // R7 corner addresses for both block sizes
    send(0, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '1);
    send(1, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '1);
    send(2, 0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_00C0);
    send(0, 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_003F);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule